// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is a register-mapped power-mode controller. Software programs a run-mode selection (normal run or very-low-power run) and a stop-mode selection (normal, very-low-power, low-leakage or very-low-leakage stop). Writes to these selections only take effect for modes that a write-once permission register has enabled since reset. The block keeps a one-hot power status and moves it between the run states one clock after a legal run-mode change is accepted.

A sleep request that arrives while deep sleep is asserted starts a fixed stop-entry handshake. If no interrupt arrives during the handshake, the status moves to the selected stop class. An interrupt during the handshake cancels entry, returns to the prior run state, and sets a sticky read-only abort flag. Each new entry clears that flag. While stopped, an interrupt wakes the block back to the run state it left.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the status reads RUN (0001), the control register reads 0x00, the permission register reads 0x00 and entering_o is low.
- R2: The permission register (address 0, bit 0 very-low-power, bit 1 low-leakage, bit 2 very-low-leakage) accepts only the first write after reset. Later writes leave it unchanged until the next reset.
- R3: The stop field (control register address 1, bits 2:0) takes code 000 (normal stop) at any time. It takes 010 (very-low-power stop) only with permission bit 0, 011 (low-leakage stop) only with bit 1, and 100 (very-low-leakage stop) only with bit 2. Any other write, including a reserved code, leaves the field unchanged.
- R4: The run field (control bits 6:5) accepts 10 (very-low-power run) only with permission bit 0 while the status is RUN. It accepts 00 (normal run) only while the status is VLPR. Codes 01 and 11 are ignored. No run write is accepted during stop entry or while stopped.
- R5: The status (address 2, bits 3:0) is one-hot, with bit 0 RUN, bit 1 VLPR, bit 2 STOP-class and bit 3 VLPS. It changes to the new run state one clock after the run-mode write is accepted.
- R6: Control bits 7 and 4 always read 0. The abort flag (control bit 3) is read-only, and writes to it are ignored.
- R7: When sleep_req_i and deep_i are high together in the run state, stop entry starts, entering_o goes high and the abort flag clears. sleep_req_i with deep_i low has no effect.
- R8: If no interrupt arrives, entry lasts 4 cycles. The status then becomes VLPS for code 010, or STOP-class for codes 000, 011 and 100, and the abort flag stays 0.
- R9: If irq_i is high in any of the 4 entry cycles, entry is cancelled, the abort flag is set and the status returns to the prior run state on the next clock.
- R10: While stopped, irq_i returns the status to the run state held before entry, and the abort flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 permission, 1 control, 2 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sleep_req_i | input | 1 | Sleep request |
| deep_i | input | 1 | Deep-sleep qualifier |
| irq_i | input | 1 | Interrupt pending |
| status_o | output | 4 | One-hot power status |
| run_mode_o | output | 2 | Current run-mode field |
| stop_mode_o | output | 3 | Current stop-mode field |
| entering_o | output | 1 | Stop entry in progress |
| stop_abort_o | output | 1 | Sticky stop-entry-aborted flag |

## Verification
The bench sweeps every permission value against every stop code, so a wrong permission bit mapping or an accepted reserved code shows up as a wrong field readback. Back-to-back run writes land in the one cycle where the status has not yet moved. A design that checked the requested field instead of the status would accept the reversal. Interrupts are placed in each of the four entry cycles, and also left out, from both run states and for every stop class. An off-by-one handshake length, a flag that does not clear on a new entry, or a wake to the wrong run state all show up as wrong status or flag values. The permission register is written twice, so a register that is not write-once reads back the second value.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam logic [1:0] RM_NORM = 2'b00;
  localparam logic [1:0] RM_VLP  = 2'b10;

  localparam logic [2:0] SM_STOP = 3'b000;
  localparam logic [2:0] SM_VLPS = 3'b010;
  localparam logic [2:0] SM_LLS  = 3'b011;
  localparam logic [2:0] SM_VLLS = 3'b100;

  localparam int ST_RUN  = 0;
  localparam int ST_VLPR = 1;
  localparam int ST_STOP = 2;
  localparam int ST_VLPS = 3;
  localparam int ST_W    = 4;

  localparam int PERM_W    = 3;
  localparam int PERM_VLP  = 0;
  localparam int PERM_LLS  = 1;
  localparam int PERM_VLLS = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_ENTER, PH_STOPPED} phase_t;

  function automatic logic stop_code_ok(input logic [2:0] code, input logic [PERM_W-1:0] perm);
    case (code)
      SM_STOP: stop_code_ok = 1'b1;
      SM_VLPS: stop_code_ok = perm[PERM_VLP];
      SM_LLS:  stop_code_ok = perm[PERM_LLS];
      SM_VLLS: stop_code_ok = perm[PERM_VLLS];
      default: stop_code_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pwr_perm_reg.sv
module pwr_perm_reg
  import pwr_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PERM_W-1:0] wdata_i,
  output logic [PERM_W-1:0] perm_o,
  output logic              first_wr_o
);
  logic              locked_q;
  logic [PERM_W-1:0] perm_q;

  assign first_wr_o = wr_i && !locked_q;
  assign perm_o     = perm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      perm_q   <= '0;
    end else if (first_wr_o) begin
      locked_q <= 1'b1;
      perm_q   <= wdata_i;
    end
  end

  assert_perm_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(perm_q));
endmodule

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic [1:0]        run_wr_i,
  input  logic [2:0]        stop_wr_i,
  input  logic [PERM_W-1:0] perm_i,
  input  logic              clr_stop_i,
  input  logic [ST_W-1:0]   status_i,
  input  logic              idle_i,
  output logic [1:0]        run_o,
  output logic [2:0]        stop_o
);
  logic [1:0] run_q;
  logic [2:0] stop_q;
  logic       run_ok;

  always_comb begin
    run_ok = 1'b0;
    if (wr_ctrl_i && idle_i) begin
      if (run_wr_i == RM_VLP)
        run_ok = perm_i[PERM_VLP] && status_i[ST_RUN];
      else if (run_wr_i == RM_NORM)
        run_ok = status_i[ST_VLPR];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= RM_NORM;
      stop_q <= SM_STOP;
    end else begin
      if (run_ok) run_q <= run_wr_i;
      if (clr_stop_i)
        stop_q <= SM_STOP;
      else if (wr_ctrl_i && stop_code_ok(stop_wr_i, perm_i))
        stop_q <= stop_wr_i;
    end
  end

  assign run_o  = run_q;
  assign stop_o = stop_q;

  assert_vlpr_needs_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && run_wr_i == RM_VLP && !status_i[ST_RUN]) |=> $stable(run_q));
  assert_norm_needs_vlpr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && run_wr_i == RM_NORM && !status_i[ST_VLPR]) |=> $stable(run_q));
endmodule

// File: rtl/pwr_stop_seq.sv
module pwr_stop_seq
  import pwr_mode_pkg::*;
#(
  parameter int ENTRY_CYCLES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sleep_req_i,
  input  logic            deep_i,
  input  logic            irq_i,
  input  logic [1:0]      run_code_i,
  input  logic [2:0]      stop_code_i,
  output logic [ST_W-1:0] status_o,
  output logic            idle_o,
  output logic            entering_o,
  output logic            abort_o
);
  localparam int CNT_W = (ENTRY_CYCLES > 2) ? $clog2(ENTRY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_CYCLES - 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cur_vlp_q;
  logic             tgt_vlps_q;
  logic             abort_q;
  logic             start;

  assign start = (phase_q == PH_IDLE) && sleep_req_i && deep_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      cur_vlp_q  <= 1'b0;
      tgt_vlps_q <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          cur_vlp_q <= (run_code_i == RM_VLP);
          if (start) begin
            phase_q    <= PH_ENTER;
            cnt_q      <= '0;
            abort_q    <= 1'b0;
            tgt_vlps_q <= (stop_code_i == SM_VLPS);
          end
        end
        PH_ENTER: begin
          if (irq_i) begin
            abort_q <= 1'b1;
            phase_q <= PH_IDLE;
          end else if (cnt_q == CNT_LAST) begin
            phase_q <= PH_STOPPED;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_STOPPED: if (irq_i) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    status_o = '0;
    if (phase_q == PH_STOPPED) status_o[tgt_vlps_q ? ST_VLPS : ST_STOP] = 1'b1;
    else                       status_o[cur_vlp_q ? ST_VLPR : ST_RUN]   = 1'b1;
  end

  assign idle_o     = (phase_q == PH_IDLE);
  assign entering_o = (phase_q == PH_ENTER);
  assign abort_o    = abort_q;

  assert_status_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o) == 1);
  assert_start_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (!abort_q && phase_q == PH_ENTER));
  assert_irq_aborts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ENTER && irq_i) |=> (abort_q && phase_q == PH_IDLE));
  assert_wake_keeps_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STOPPED && irq_i) |=> (phase_q == PH_IDLE && $stable(cur_vlp_q)));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int ENTRY_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       sleep_req_i,
  input  logic       deep_i,
  input  logic       irq_i,
  output logic [3:0] status_o,
  output logic [1:0] run_mode_o,
  output logic [2:0] stop_mode_o,
  output logic       entering_o,
  output logic       stop_abort_o
);
  localparam logic [1:0] A_PERM = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  logic [PERM_W-1:0] perm;
  logic              first_wr;
  logic [ST_W-1:0]   status;
  logic              idle;
  logic [1:0]        run_q;
  logic [2:0]        stop_q;
  logic              abort;

  pwr_perm_reg u_perm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i && addr_i == A_PERM),
    .wdata_i    (wdata_i[PERM_W-1:0]),
    .perm_o     (perm),
    .first_wr_o (first_wr)
  );

  pwr_mode_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr_en_i && addr_i == A_CTRL),
    .run_wr_i   (wdata_i[6:5]),
    .stop_wr_i  (wdata_i[2:0]),
    .perm_i     (perm),
    .clr_stop_i (first_wr),
    .status_i   (status),
    .idle_i     (idle),
    .run_o      (run_q),
    .stop_o     (stop_q)
  );

  pwr_stop_seq #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .deep_i      (deep_i),
    .irq_i       (irq_i),
    .run_code_i  (run_q),
    .stop_code_i (stop_q),
    .status_o    (status),
    .idle_o      (idle),
    .entering_o  (entering_o),
    .abort_o     (abort)
  );

  always_comb begin
    case (addr_i)
      A_PERM:  rdata_o = {{(8-PERM_W){1'b0}}, perm};
      A_CTRL:  rdata_o = {1'b0, run_q, 1'b0, abort, stop_q};
      A_STAT:  rdata_o = {{(8-ST_W){1'b0}}, status};
      default: rdata_o = 8'h00;
    endcase
  end

  assign status_o     = status;
  assign run_mode_o   = run_q;
  assign stop_mode_o  = stop_q;
  assign stop_abort_o = abort;
endmodule

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sleep_req = 1'b0;
  logic       deep = 1'b0;
  logic       irq = 1'b0;
  logic [3:0] status;
  logic [1:0] run_mode;
  logic [2:0] stop_mode;
  logic       entering;
  logic       stop_abort;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwr_mode_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sleep_req_i(sleep_req), .deep_i(deep), .irq_i(irq),
    .status_o(status), .run_mode_o(run_mode), .stop_mode_o(stop_mode),
    .entering_o(entering), .stop_abort_o(stop_abort)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0; sleep_req = 1'b0; deep = 1'b0; irq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic done();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    logic [7:0] d;
    logic [2:0] exp_stop;
    logic [3:0] run_st;
    logic [3:0] stop_st;
    logic       ok;
    logic       hit;

    do_reset();
    rd(2, d); chk("R1 status", d, 8'h01);
    rd(1, d); chk("R1 ctrl", d, 8'h00);
    rd(0, d); chk("R1 perm", d, 8'h00);
    chk("R1 entering", entering, 1'b0);

    // R2, R3, R6: every permission against every stop code
    for (int p = 0; p < 8; p++) begin
      do_reset();
      wr(0, 8'(p));
      rd(0, d); chk("R2 first perm write", d, 8'(p));
      wr(0, ~8'(p));
      rd(0, d); chk("R2 second perm write ignored", d, 8'(p));
      exp_stop = 3'b000;
      for (int c = 0; c < 8; c++) begin
        ok = (c == 0) || (c == 2 && p[0]) || (c == 3 && p[1]) || (c == 4 && p[2]);
        if (ok) exp_stop = 3'(c);
        wr(1, {1'b1, 2'b00, 1'b1, 1'b1, 3'(c)});
        rd(1, d); chk("R3 R6 stop field and reserved bits", d, {5'b0, exp_stop});
      end
    end

    // R4, R5
    do_reset();
    wr(1, 8'h40);
    rd(1, d); chk("R4 VLPR without permission", d, 8'h00);
    wr(0, 8'h01);
    wr(1, 8'h20);
    rd(1, d); chk("R4 reserved run 01", d, 8'h00);
    wr(1, 8'h60);
    rd(1, d); chk("R4 reserved run 11", d, 8'h00);
    wr(1, 8'h40);
    chk("R5 status not yet moved", status, 4'b0001);
    chk("R4 VLPR accepted", run_mode, 2'b10);
    wr(1, 8'h00);
    chk("R5 status VLPR one clock later", status, 4'b0010);
    chk("R4 RUN rejected while status RUN", run_mode, 2'b10);
    wr(1, 8'h00);
    chk("R4 RUN accepted from VLPR", run_mode, 2'b00);
    chk("R5 status still VLPR", status, 4'b0010);
    wr(1, 8'h40);
    chk("R4 VLPR rejected while status VLPR", run_mode, 2'b00);
    rd(2, d); chk("R5 status back to RUN", d, 8'h01);

    // R7: sleep without deep
    sleep_req = 1'b1; deep = 1'b0;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R7 no deep no entry", entering, 1'b0);
    chk("R7 status unchanged", status, 4'b0001);

    // R7-R10 sweep
    for (int v = 0; v < 2; v++) begin
      for (int ci = 0; ci < 4; ci++) begin
        for (int at = 0; at < 5; at++) begin
          logic [2:0] code;
          code = (ci == 0) ? 3'b000 : (ci == 1) ? 3'b010 : (ci == 2) ? 3'b011 : 3'b100;
          do_reset();
          wr(0, 8'h07);
          if (v == 1) begin
            wr(1, 8'h40);
            @(negedge clk);
          end
          run_st  = (v == 1) ? 4'b0010 : 4'b0001;
          stop_st = (code == 3'b010) ? 4'b1000 : 4'b0100;
          wr(1, {1'b0, (v == 1) ? 2'b10 : 2'b00, 2'b00, code});
          chk("R3 code stored", stop_mode, code);
          sleep_req = 1'b1; deep = 1'b1;
          @(negedge clk);
          sleep_req = 1'b0; deep = 1'b0;
          chk("R7 entering", entering, 1'b1);
          chk("R7 abort clear", stop_abort, 1'b0);
          hit = 1'b0;
          for (int k = 0; k < 4; k++) begin
            if (!hit) begin
              chk("R9 status held during entry", status, run_st);
              irq = (k == at);
              @(negedge clk);
              irq = 1'b0;
              if (k == at) begin
                hit = 1'b1;
                chk("R9 abort set", stop_abort, 1'b1);
                chk("R9 back to run", status, run_st);
                chk("R9 entering low", entering, 1'b0);
                rd(1, d); chk("R6 abort readable", d[3], 1'b1);
              end
            end
          end
          if (hit) begin
            // R7: new entry clears the flag
            sleep_req = 1'b1; deep = 1'b1;
            @(negedge clk);
            sleep_req = 1'b0; deep = 1'b0;
            chk("R7 new entry clears abort", stop_abort, 1'b0);
            irq = 1'b1;
            @(negedge clk);
            irq = 1'b0;
            chk("R9 second abort", stop_abort, 1'b1);
          end else begin
            chk("R8 stop class", status, stop_st);
            chk("R8 abort clear", stop_abort, 1'b0);
            chk("R8 entering low", entering, 1'b0);
            @(negedge clk);
            chk("R10 stays stopped", status, stop_st);
            irq = 1'b1;
            @(negedge clk);
            irq = 1'b0;
            chk("R10 wake state", status, run_st);
            chk("R10 abort stays clear", stop_abort, 1'b0);
          end
        end
      end
    end

    done();
  end
endmodule